// File: doc/BRIEF.md
# Function Result Reuse Table

This block remembers the results of calls to functions that have no side effects, so that a processor front end can skip a call it has already seen. When a call instruction is decoded, the front end presents the call target, up to two argument values with a valid bit for each, and an eligibility bit. The eligibility bit is set by earlier tooling to mark the function as free of side effects. One cycle later the block answers with a hit and the stored return value, or with a miss.

On an eligible miss the block keeps the call's key in a single pending slot. When the front end reports that the call returned, the block writes the key and the returned value into the table. The table is set associative. The set is chosen by a hash of the target and the argument values, and the least recently used way is replaced. A flush input drops every entry and the pending slot. The front end uses it when code or data change in a way that breaks the no-side-effect assumption.

Top module: `fn_memo_table`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise, including after reset.
- R2: A request with `req_elig` low is answered as a miss even when a matching entry exists. It allocates nothing, so a later return does not create an entry for it.
- R3: After an eligible miss followed by a return carrying value V, a later identical eligible request hits and `rsp_result` equals V.
- R4: Two keys match only when the targets are equal, both argument valid bits are equal, and the values of the valid arguments are equal. The value of an argument whose valid bit is low is ignored.
- R5: On any response that is a miss, `rsp_result` is zero.
- R6: The pending slot is cleared by the return that fills it. A return that arrives while no call is pending changes no entry.
- R7: Only the most recent eligible miss is pending. A newer miss replaces an older one before the older one's return.
- R8: `flush` invalidates every entry and the pending slot. A request presented in the same cycle as `flush` is answered as a miss.
- R9: The set index bit b is the XOR of every bit j of (target XOR masked arg0 XOR masked arg1) with j mod SET_W = b, where SET_W = log2(ENTRIES/WAYS). A fill takes the lowest-numbered invalid way of the set, and otherwise the least recently used way. Both hits and fills make a way the most recently used.
- R10: A request whose key equals the pending key, arriving in the same cycle as the return that fills it, hits and returns that cycle's `ret_result`.
- R11: At most one way of a set ever matches a lookup key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and the pending call |
| req_valid | input | 1 | Call decoded this cycle |
| req_elig | input | 1 | Callee is marked free of side effects |
| req_target | input | W | Call target address |
| req_a0_vld | input | 1 | First argument present |
| req_a0 | input | W | First argument value |
| req_a1_vld | input | 1 | Second argument present |
| req_a1 | input | W | Second argument value |
| ret_valid | input | 1 | The pending call has returned |
| ret_result | input | W | Value returned by that call |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Stored result found; the call may be skipped |
| rsp_result | output | W | Stored result on a hit, zero on a miss |

## Verification
On every cycle the assertions check the response timing, that misses carry a zero result, that ineligible and flush-cycle requests never hit, that a flush empties the pending slot, and that no lookup key matches more than one way. Only the bench's scenarios can show the content-dependent behaviour: a stored value coming back after its return, argument masking by the valid bits, the replacement of an older pending call by a newer one, and forwarding of a same-cycle return. The same holds for the choice of eviction victim, which the bench exercises by filling one set with colliding keys, refreshing one entry and then overflowing the set.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  parameter int unsigned FMT_W = 32;

  typedef struct packed {
    logic [FMT_W-1:0] tgt;
    logic             v0;
    logic             v1;
    logic [FMT_W-1:0] a0;
    logic [FMT_W-1:0] a1;
  } fmt_key_t;

  // Arguments whose valid bit is low are cleared so they never affect matching.
  function automatic fmt_key_t make_key(input logic [FMT_W-1:0] tgt,
                                        input logic v0, input logic [FMT_W-1:0] a0,
                                        input logic v1, input logic [FMT_W-1:0] a1);
    fmt_key_t k;
    k.tgt = tgt;
    k.v0  = v0;
    k.v1  = v1;
    k.a0  = v0 ? a0 : '0;
    k.a1  = v1 ? a1 : '0;
    return k;
  endfunction
endpackage

// File: rtl/fmt_hash.sv
module fmt_hash #(
  parameter int unsigned W     = 32,
  parameter int unsigned SET_W = 5
) (
  input  logic [W-1:0]     word,
  output logic [SET_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int j = 0; j < W; j++) begin
      idx[j % SET_W] = idx[j % SET_W] ^ word[j];
    end
  end
endmodule

// File: rtl/fmt_lru.sv
module fmt_lru #(
  parameter int unsigned SETS = 32,
  parameter int unsigned WAYS = 4,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned AW    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_touch,
  input  logic [SET_W-1:0] hit_set,
  input  logic [AW-1:0]    hit_way,
  input  logic             fill_touch,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAYS-1:0]  fill_vld,
  output logic [AW-1:0]    fill_way
);
  typedef logic [WAYS-1:0][AW-1:0] row_t;

  row_t age_q [SETS];
  row_t hit_row, fill_base, fill_row;

  function automatic row_t touch(input row_t r, input logic [AW-1:0] way);
    row_t n;
    for (int i = 0; i < WAYS; i++) begin
      if (AW'(i) == way)      n[i] = '0;
      else if (r[i] < r[way]) n[i] = r[i] + 1'b1;
      else                    n[i] = r[i];
    end
    return n;
  endfunction

  always_comb begin
    hit_row   = touch(age_q[hit_set], hit_way);
    fill_base = (hit_touch && hit_set == fill_set) ? hit_row : age_q[fill_set];
    fill_way  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (fill_base[i] == AW'(WAYS - 1)) fill_way = AW'(i);
    end
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!fill_vld[i]) fill_way = AW'(i);
    end
    fill_row = touch(fill_base, fill_way);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int i = 0; i < WAYS; i++) age_q[s][i] <= AW'(i);
      end
    end else begin
      if (hit_touch)  age_q[hit_set]  <= hit_row;
      if (fill_touch) age_q[fill_set] <= fill_row;
    end
  end
endmodule

// File: rtl/fn_memo_table.sv
module fn_memo_table
  import fmt_pkg::*;
#(
  parameter int unsigned W       = fmt_pkg::FMT_W,
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned WAYS    = 4,
  localparam int unsigned SETS   = ENTRIES / WAYS,
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned AW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         req_valid,
  input  logic         req_elig,
  input  logic [W-1:0] req_target,
  input  logic         req_a0_vld,
  input  logic [W-1:0] req_a0,
  input  logic         req_a1_vld,
  input  logic [W-1:0] req_a1,
  input  logic         ret_valid,
  input  logic [W-1:0] ret_result,
  output logic         rsp_valid,
  output logic         rsp_hit,
  output logic [W-1:0] rsp_result
);
  fmt_key_t         lk_key;
  logic [SET_W-1:0] lk_set;
  logic [WAYS-1:0]  way_hit;
  fmt_key_t         rd_key [WAYS];
  logic [W-1:0]     rd_res [WAYS];
  logic             hit_any;
  logic [W-1:0]     hit_res;
  logic [AW-1:0]    hit_way;

  logic             pend_vld;
  fmt_key_t         pend_key;
  logic [SET_W-1:0] pend_set;
  logic [WAYS-1:0]  vld_q [SETS];

  logic             lookup_en, fill_we, fwd, hit_now, miss_alloc, hit_touch;
  logic [AW-1:0]    fill_way;
  logic [W-1:0]     hit_val;

  assign lk_key = make_key(req_target, req_a0_vld, req_a0, req_a1_vld, req_a1);

  fmt_hash #(.W(W), .SET_W(SET_W)) u_hash (
    .word (lk_key.tgt ^ lk_key.a0 ^ lk_key.a1),
    .idx  (lk_set)
  );

  assign fill_we = ret_valid && pend_vld && !flush;

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
    fmt_key_t     key_mem [SETS];
    logic [W-1:0] res_mem [SETS];

    always_ff @(posedge clk) begin
      if (fill_we && fill_way == AW'(gw)) begin
        key_mem[pend_set] <= pend_key;
        res_mem[pend_set] <= ret_result;
      end
    end

    assign rd_key[gw]  = key_mem[lk_set];
    assign rd_res[gw]  = res_mem[lk_set];
    assign way_hit[gw] = vld_q[lk_set][gw] && (rd_key[gw] == lk_key);
  end

  always_comb begin
    hit_res = '0;
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (way_hit[i]) begin
        hit_res = hit_res | rd_res[i];
        hit_way = AW'(i);
      end
    end
  end

  assign hit_any    = |way_hit;
  assign lookup_en  = req_valid && req_elig && !flush;
  assign fwd        = fill_we && lookup_en && (lk_key == pend_key);
  assign hit_now    = lookup_en && (hit_any || fwd);
  assign hit_touch  = lookup_en && hit_any && !fwd;
  assign miss_alloc = lookup_en && !hit_any && !fwd;
  assign hit_val    = fwd ? ret_result : hit_res;

  fmt_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .hit_touch  (hit_touch),
    .hit_set    (lk_set),
    .hit_way    (hit_way),
    .fill_touch (fill_we),
    .fill_set   (pend_set),
    .fill_vld   (vld_q[pend_set]),
    .fill_way   (fill_way)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_vld <= 1'b0;
    end else if (miss_alloc) begin
      pend_vld <= 1'b1;
    end else if (fill_we) begin
      pend_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (miss_alloc) begin
      pend_key <= lk_key;
      pend_set <= lk_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_we) begin
      vld_q[pend_set][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_result <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= hit_now;
      rsp_result <= hit_now ? hit_val : '0;
    end
  end
endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int unsigned W    = 32,
  parameter int unsigned WAYS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            req_valid,
  input logic            req_elig,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [W-1:0]    rsp_result,
  input logic [WAYS-1:0] way_hit,
  input logic            pend_vld
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_inelig_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_elig) |=> !rsp_hit);
  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_result == '0));
  assert_hit_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  assert_flush_miss_R8: assert property (@(posedge clk) disable iff (rst)
    (flush && req_valid) |=> !rsp_hit);
  assert_flush_clears_pending_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pend_vld);
  assert_single_match_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
endmodule

bind fn_memo_table fmt_checker #(.W(W), .WAYS(WAYS)) u_fmt_checker (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .req_valid  (req_valid),
  .req_elig   (req_elig),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_result (rsp_result),
  .way_hit    (way_hit),
  .pend_vld   (pend_vld)
);

// File: tb/tb_fn_memo_table.sv
module tb_fn_memo_table;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst, flush, req_valid, req_elig, req_a0_vld, req_a1_vld, ret_valid;
  logic [W-1:0] req_target, req_a0, req_a1, ret_result;
  logic rsp_valid, rsp_hit;
  logic [W-1:0] rsp_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit           exp_hit_q [$];
  logic [W-1:0] exp_res_q [$];
  string        tag_q [$];

  always #2 clk = ~clk;

  fn_memo_table dut (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_elig(req_elig), .req_target(req_target),
    .req_a0_vld(req_a0_vld), .req_a0(req_a0), .req_a1_vld(req_a1_vld), .req_a1(req_a1),
    .ret_valid(ret_valid), .ret_result(ret_result),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_result(rsp_result)
  );

  // One cycle of stimulus; the expected answer is queued for the monitor.
  task automatic drive(input bit rv, input bit el, input logic [W-1:0] tg,
                       input bit v0, input logic [W-1:0] a0,
                       input bit v1, input logic [W-1:0] a1,
                       input bit rt, input logic [W-1:0] rr, input bit fl,
                       input bit eh, input logic [W-1:0] er, input string tag);
    @(negedge clk);
    req_valid = rv; req_elig = el; req_target = tg;
    req_a0_vld = v0; req_a0 = a0; req_a1_vld = v1; req_a1 = a1;
    ret_valid = rt; ret_result = rr; flush = fl;
    if (rv) begin
      exp_hit_q.push_back(eh);
      exp_res_q.push_back(er);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 0; ret_valid = 0; flush = 0;
  endtask

  task automatic req(input logic [W-1:0] tg, input bit v0, input logic [W-1:0] a0,
                     input bit v1, input logic [W-1:0] a1,
                     input bit eh, input logic [W-1:0] er, input string tag);
    drive(1, 1, tg, v0, a0, v1, a1, 0, '0, 0, eh, er, tag);
  endtask

  task automatic ret(input logic [W-1:0] v);
    drive(0, 0, '0, 0, '0, 0, '0, 1, v, 0, 0, '0, "");
  endtask

  // Monitor: compares every response against the oldest queued expectation.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_hit_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected response hit=%0b result=%h, expected none", rsp_hit, rsp_result);
      end else begin
        bit eh; logic [W-1:0] er; string tg;
        eh = exp_hit_q.pop_front(); er = exp_res_q.pop_front(); tg = tag_q.pop_front();
        if (rsp_hit !== eh || rsp_result !== er) begin
          errors++;
          $display("FAIL %s hit=%0b result=%h, expected hit=%0b result=%h",
                   tg, rsp_hit, rsp_result, eh, er);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; flush = 0; req_valid = 0; req_elig = 0; req_target = '0;
    req_a0_vld = 0; req_a0 = '0; req_a1_vld = 0; req_a1 = '0;
    ret_valid = 0; ret_result = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R1 rsp_valid=%0b after reset, expected 0", rsp_valid);
    end

    // R3/R5: miss, return, then hit with the stored value
    req(32'h1000, 1, 5, 1, 7, 0, '0, "R3 first call misses (R5 zero)");
    ret(32'hCAFE0001);
    req(32'h1000, 1, 5, 1, 7, 1, 32'hCAFE0001, "R3 repeat call hits");

    // R6: stray return must not overwrite the entry
    ret(32'hBAD0BAD0);
    req(32'h1000, 1, 5, 1, 7, 1, 32'hCAFE0001, "R6 stray return ignored");

    // R4: matching rules
    req(32'h2000, 1, 3, 0, 32'h1111, 0, '0, "R4 one-arg miss");
    ret(32'h00000033);
    req(32'h2000, 1, 3, 0, 32'hDEAD, 1, 32'h33, "R4 invalid arg value ignored");
    req(32'h2000, 1, 3, 1, 32'h0, 0, '0, "R4 arg valid bit differs");
    req(32'h2000, 1, 4, 0, 32'h0, 0, '0, "R4 arg value differs");
    req(32'h2004, 1, 3, 0, 32'h0, 0, '0, "R4 target differs");

    // R7: newer miss replaces older pending call
    req(32'h3000, 0, 0, 0, 0, 0, '0, "R7 miss A");
    req(32'h3100, 0, 0, 0, 0, 0, '0, "R7 miss B");
    ret(32'h77);
    req(32'h3100, 0, 0, 0, 0, 1, 32'h77, "R7 newer call filled");
    req(32'h3000, 0, 0, 0, 0, 0, '0, "R7 older call not filled");
    ret(32'h78);

    // R2: ineligible requests
    drive(1, 0, 32'h1000, 1, 5, 1, 7, 0, '0, 0, 0, '0, "R2 ineligible never hits");
    drive(1, 0, 32'h4000, 0, 0, 0, 0, 0, '0, 0, 0, '0, "R2 ineligible miss");
    ret(32'h99);
    req(32'h4000, 0, 0, 0, 0, 0, '0, "R2 no allocation from ineligible");
    ret(32'h9A);

    // R10: request and its return in the same cycle
    req(32'h5000, 1, 9, 0, 0, 0, '0, "R10 miss F");
    drive(1, 1, 32'h5000, 1, 9, 0, 0, 1, 32'h44, 0, 1, 32'h44, "R10 forwarded result");
    req(32'h5000, 1, 9, 0, 0, 1, 32'h44, "R10 stored once");

    // R8: flush
    drive(1, 1, 32'h1000, 1, 5, 1, 7, 0, '0, 1, 0, '0, "R8 flush-cycle request misses");
    req(32'h1000, 1, 5, 1, 7, 0, '0, "R8 entry gone after flush");
    drive(0, 0, '0, 0, '0, 0, '0, 0, '0, 1, 0, '0, "");
    ret(32'h66);
    req(32'h1000, 1, 5, 1, 7, 0, '0, "R8 pending dropped by flush");
    drive(0, 0, '0, 0, '0, 0, '0, 0, '0, 1, 0, '0, "");

    // R9: five keys folding to set 0 (arg0 = k*33 cancels in the fold)
    for (int k = 1; k <= 4; k++) begin
      req(32'h0, 1, k * 33, 0, 0, 0, '0, "R9 fill set");
      ret(32'h100 + k);
    end
    req(32'h0, 1, 1 * 33, 0, 0, 1, 32'h101, "R9 refresh key1");
    req(32'h0, 1, 5 * 33, 0, 0, 0, '0, "R9 fifth key misses");
    ret(32'h105);
    req(32'h0, 1, 2 * 33, 0, 0, 0, '0, "R9 LRU key2 evicted");
    req(32'h0, 1, 1 * 33, 0, 0, 1, 32'h101, "R9 refreshed key1 kept");
    req(32'h0, 1, 3 * 33, 0, 0, 1, 32'h103, "R9 key3 kept");
    req(32'h0, 1, 4 * 33, 0, 0, 1, 32'h104, "R9 key4 kept");
    req(32'h0, 1, 5 * 33, 0, 0, 1, 32'h105, "R9 key5 stored");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_hit_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses: %0d, expected 0", exp_hit_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule